// File: doc/BRIEF.md
# Snoop Launch and Write-Back Backoff Controller

This block is the system-side sequencer that runs a cache snoop against a processor on a shared bus. Another bus master posts a snoop request made of a line address and an invalidate flag. The block places the request in a one-deep holding slot. When it is free, it takes the processor's address bus away, drives a one-clock external snoop strobe with the address and the invalidate flag, and then samples the processor's modified-hit response on a fixed clock script.

If the processor reports a modified line while its own burst is still unfinished, the block raises a backoff for a fixed number of clocks. The backoff flushes the processor's bus pipeline, so the write-back goes out first and the aborted burst is reissued later. While backoff is high, ready strobes for the aborted burst are masked, so partial data is never accepted. After the backoff the block releases the address bus so the processor can drive the write-back. It starts no further snoop until the modified-hit signal drops again.

All pins use active-high logic levels. Any low-active bus levels are inverted at the pads, outside this block.

Top module: `snoop_backoff_ctrl`

## Requirements
- R1: While reset is asserted and just after it, addrHoldO, snoopStrbO, snoopInvO, backoffO and readyAcceptO are 0, snoopAddrO is 0 and reqReadyO is 1.
- R2: A request with reqValidI=1 is captured at a rising edge only while reqReadyO=1. reqReadyO reads 0 while the slot holds a request, and a request offered then is dropped. When the controller is idle, addrHoldO rises at the first edge after the capturing edge, and the slot is freed at that same edge.
- R3: snoopStrbO is high for exactly one clock, starting at the second edge after addrHoldO rises. addrHoldO stays high through it.
- R4: During the strobe clock, snoopInvO equals the request's invalidate flag and snoopAddrO equals its address. snoopInvO is 0 at all other times. snoopAddrO does not change while addrHoldO stays high.
- R5: modHitI is sampled at the second edge after the strobe clock ends (the third edge after the strobe rises). If it is 0, addrHoldO falls at that edge and the snoop ends.
- R6: If modHitI=1 at that sample and a processor burst is open, backoffO is high for exactly one clock starting at that edge. addrHoldO stays high during backoff and falls when backoff ends.
- R7: If modHitI=1 at that sample and no burst is open, backoffO stays 0 and addrHoldO falls at that edge.
- R8: A burst opens on cpuAddrStrbI=1. It closes on cpuReadyI=1 with cpuLastI=1, and a final transfer seen at the sampling edge itself counts as closed. A backoff aborts it, so a later snoop does not see it as open.
- R9: readyAcceptO is cpuReadyI masked by backoffO: it is 0 in every clock where backoffO is 1.
- R10: After a modified hit, no new snoop starts while modHitI stays 1. A pending request's addrHoldO rises at the first edge after the edge that samples modHitI=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValidI | input | 1 | Snoop request offered |
| reqAddrI | input | ADDR_W | Line address to snoop |
| reqInvI | input | 1 | Invalidate the line on snoop |
| reqReadyO | output | 1 | Holding slot free |
| cpuAddrStrbI | input | 1 | Processor starts a bus cycle |
| cpuReadyI | input | 1 | Transfer ready from memory side |
| cpuLastI | input | 1 | Final transfer of the burst |
| modHitI | input | 1 | Processor reports a modified hit |
| addrHoldO | output | 1 | Processor address bus taken over |
| snoopStrbO | output | 1 | External snoop strobe, one clock |
| snoopInvO | output | 1 | Invalidate qualifier of the strobe |
| snoopAddrO | output | ADDR_W | Snoop address |
| backoffO | output | 1 | Abort processor cycles |
| readyAcceptO | output | 1 | Ready accepted for the current burst |

## Verification
Two things can happen on the same edge. The processor's final burst transfer can land on the edge that samples the modified hit, and a ready can arrive while backoff is asserted. One vector drives cpuReadyI and cpuLastI exactly on the sampling edge and expects no backoff. Another vector raises cpuReadyI during the backoff clock and expects readyAcceptO to stay 0. A third case opens a burst, lets an earlier snoop miss, and then hits with no new burst. That case checks that the still-open burst triggers backoff and that the abort clears it for the snoop after.

// File: rtl/snoopbk_pkg.sv
package snoopbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_STROBE,
    ST_PROBE,
    ST_BACKOFF,
    ST_WBWAIT
  } snoopState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;      // move slot into the working register
    logic cntClr;      // restart the step counter
    logic abortBurst;  // backoff flushes the open burst
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic slotValid;
    logic burstOpen;
  } dpStatus_t;

endpackage

// File: rtl/snoopbk_datapath.sv
module snoopbk_datapath
  import snoopbk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValidI,
  input  logic [ADDR_W-1:0] reqAddrI,
  input  logic              reqInvI,
  input  logic              cpuAddrStrbI,
  input  logic              cpuReadyI,
  input  logic              cpuLastI,
  input  ctrlStrobe_t       strb,
  output logic              reqReadyO,
  output logic [ADDR_W-1:0] workAddrO,
  output logic              workInvO,
  output dpStatus_t         status,
  output logic [CNT_W-1:0]  stepCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              slotValid;
  logic [ADDR_W-1:0] slotAddr;
  logic              slotInv;
  logic              burstOpenQ;
  logic              finalXfer;

  assign reqReadyO = !slotValid;
  assign finalXfer = cpuReadyI && cpuLastI;

  // one-deep holding slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      slotAddr  <= '0;
      slotInv   <= 1'b0;
    end else if (strb.launch) begin
      slotValid <= 1'b0;
    end else if (reqValidI && !slotValid) begin
      slotValid <= 1'b1;
      slotAddr  <= reqAddrI;
      slotInv   <= reqInvI;
    end
  end

  // working snoop register, held for the whole snoop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workAddrO <= '0;
      workInvO  <= 1'b0;
    end else if (strb.launch) begin
      workAddrO <= slotAddr;
      workInvO  <= slotInv;
    end
  end

  // step counter for the fixed clock script
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stepCnt <= '0;
    else if (strb.cntClr)     stepCnt <= '0;
    else if (stepCnt != CNT_MAX) stepCnt <= stepCnt + 1'b1;
  end

  // processor burst tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 burstOpenQ <= 1'b0;
    else if (strb.abortBurst)  burstOpenQ <= 1'b0;
    else if (cpuAddrStrbI)     burstOpenQ <= 1'b1;
    else if (finalXfer)        burstOpenQ <= 1'b0;
  end

  assign status.slotValid = slotValid;
  assign status.burstOpen = burstOpenQ && !finalXfer;

endmodule

// File: rtl/snoopbk_control.sv
module snoopbk_control
  import snoopbk_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int HOLD_CYC  = 2,
  parameter int PROBE_CYC = 2,
  parameter int BOFF_CYC  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStatus_t        status,
  input  logic [CNT_W-1:0] stepCnt,
  input  logic             modHitI,
  output ctrlStrobe_t      strb,
  output logic             addrHoldO,
  output logic             snoopStrbO,
  output logic             backoffO
);

  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] PROBE_LAST = CNT_W'(PROBE_CYC - 1);
  localparam logic [CNT_W-1:0] BOFF_LAST  = CNT_W'(BOFF_CYC - 1);

  snoopState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    if (status.slotValid) nextState = ST_HOLD;
      ST_HOLD:    if (stepCnt == HOLD_LAST) nextState = ST_STROBE;
      ST_STROBE:  nextState = ST_PROBE;
      ST_PROBE: begin
        if (stepCnt == PROBE_LAST) begin
          if (!modHitI)              nextState = ST_IDLE;
          else if (status.burstOpen) nextState = ST_BACKOFF;
          else                       nextState = ST_WBWAIT;
        end
      end
      ST_BACKOFF: if (stepCnt == BOFF_LAST) nextState = ST_WBWAIT;
      ST_WBWAIT:  if (!modHitI) nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.launch     = (state == ST_IDLE) && (nextState == ST_HOLD);
    strb.cntClr     = (nextState != state);
    strb.abortBurst = (state == ST_BACKOFF);
  end

  assign addrHoldO  = (state == ST_HOLD) || (state == ST_STROBE) ||
                      (state == ST_PROBE) || (state == ST_BACKOFF);
  assign snoopStrbO = (state == ST_STROBE);
  assign backoffO   = (state == ST_BACKOFF);

endmodule

// File: rtl/snoop_backoff_ctrl.sv
module snoop_backoff_ctrl
  import snoopbk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int HOLD_CYC  = 2,
  parameter int PROBE_CYC = 2,
  parameter int BOFF_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValidI,
  input  logic [ADDR_W-1:0] reqAddrI,
  input  logic              reqInvI,
  output logic              reqReadyO,
  input  logic              cpuAddrStrbI,
  input  logic              cpuReadyI,
  input  logic              cpuLastI,
  input  logic              modHitI,
  output logic              addrHoldO,
  output logic              snoopStrbO,
  output logic              snoopInvO,
  output logic [ADDR_W-1:0] snoopAddrO,
  output logic              backoffO,
  output logic              readyAcceptO
);

  localparam int MAX_HP  = (HOLD_CYC > PROBE_CYC) ? HOLD_CYC : PROBE_CYC;
  localparam int MAX_CYC = (MAX_HP > BOFF_CYC) ? MAX_HP : BOFF_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  ctrlStrobe_t      strb;
  dpStatus_t        status;
  logic [CNT_W-1:0] stepCnt;
  logic             workInv;

  snoopbk_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqValidI    (reqValidI),
    .reqAddrI     (reqAddrI),
    .reqInvI      (reqInvI),
    .cpuAddrStrbI (cpuAddrStrbI),
    .cpuReadyI    (cpuReadyI),
    .cpuLastI     (cpuLastI),
    .strb         (strb),
    .reqReadyO    (reqReadyO),
    .workAddrO    (snoopAddrO),
    .workInvO     (workInv),
    .status       (status),
    .stepCnt      (stepCnt)
  );

  snoopbk_control #(
    .CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC), .PROBE_CYC(PROBE_CYC), .BOFF_CYC(BOFF_CYC)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .stepCnt    (stepCnt),
    .modHitI    (modHitI),
    .strb       (strb),
    .addrHoldO  (addrHoldO),
    .snoopStrbO (snoopStrbO),
    .backoffO   (backoffO)
  );

  assign snoopInvO    = snoopStrbO && workInv;
  assign readyAcceptO = cpuReadyI && !backoffO;

endmodule

// File: rtl/snoop_backoff_ctrl_chk.sv
module snoop_backoff_ctrl_chk #(
  parameter int ADDR_W   = 32,
  parameter int BOFF_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              modHitI,
  input logic              addrHoldO,
  input logic              snoopStrbO,
  input logic              snoopInvO,
  input logic [ADDR_W-1:0] snoopAddrO,
  input logic              backoffO,
  input logic              readyAcceptO
);

  logic [7:0] boffRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         boffRun <= '0;
    else if (backoffO) boffRun <= boffRun + 1'b1;
    else               boffRun <= '0;
  end

  a_r3_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    snoopStrbO |=> !snoopStrbO);

  a_r3_hold_leads_strobe: assert property (@(posedge clk) disable iff (!rstN)
    snoopStrbO |-> (addrHoldO && $past(addrHoldO) && $past(addrHoldO, 2)));

  a_r4_inv_only_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    snoopInvO |-> snoopStrbO);

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (addrHoldO && $past(addrHoldO)) |-> $stable(snoopAddrO));

  a_r6_boff_after_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(backoffO) |-> ($past(modHitI) && addrHoldO));

  a_r6_boff_length: assert property (@(posedge clk) disable iff (!rstN)
    backoffO |-> (boffRun < 8'(BOFF_CYC)));

  a_r9_ready_masked: assert property (@(posedge clk) disable iff (!rstN)
    backoffO |-> !readyAcceptO);

  a_r10_no_start_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrHoldO) |-> !$past(modHitI));

endmodule

bind snoop_backoff_ctrl snoop_backoff_ctrl_chk #(.ADDR_W(ADDR_W), .BOFF_CYC(BOFF_CYC)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .modHitI      (modHitI),
  .addrHoldO    (addrHoldO),
  .snoopStrbO   (snoopStrbO),
  .snoopInvO    (snoopInvO),
  .snoopAddrO   (snoopAddrO),
  .backoffO     (backoffO),
  .readyAcceptO (readyAcceptO)
);

// File: tb/tb_snoop_backoff_ctrl.sv
module tb_snoop_backoff_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              inv;
    logic              hit;
    logic              openBurst;
    logic              finAtSample;
    logic              expBoff;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // miss, burst left open
    '{32'h0000_2080, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // hit, earlier burst still open
    '{32'h0000_30C0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // hit, burst aborted before (R8)
    '{32'h0000_4100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // hit, last transfer on sample edge
    '{32'hDEAD_BEE0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // hit, fresh open burst
    '{32'h0000_5140, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}   // plain miss
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValidI = 1'b0;
  logic [ADDR_W-1:0] reqAddrI = '0;
  logic              reqInvI = 1'b0;
  logic              reqReadyO;
  logic              cpuAddrStrbI = 1'b0;
  logic              cpuReadyI = 1'b0;
  logic              cpuLastI = 1'b0;
  logic              modHitI = 1'b0;
  logic              addrHoldO, snoopStrbO, snoopInvO, backoffO, readyAcceptO;
  logic [ADDR_W-1:0] snoopAddrO;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  snoop_backoff_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN),
    .reqValidI(reqValidI), .reqAddrI(reqAddrI), .reqInvI(reqInvI), .reqReadyO(reqReadyO),
    .cpuAddrStrbI(cpuAddrStrbI), .cpuReadyI(cpuReadyI), .cpuLastI(cpuLastI),
    .modHitI(modHitI),
    .addrHoldO(addrHoldO), .snoopStrbO(snoopStrbO), .snoopInvO(snoopInvO),
    .snoopAddrO(snoopAddrO), .backoffO(backoffO), .readyAcceptO(readyAcceptO)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    if (v.openBurst) begin
      cpuAddrStrbI = 1'b1;
      @(negedge clk);
      cpuAddrStrbI = 1'b0;
    end
    reqValidI = 1'b1; reqAddrI = v.addr; reqInvI = v.inv;
    @(negedge clk);                                   // E0 captured
    reqValidI = 1'b0;
    chk($sformatf("R2 v%0d slot full", idx), 64'(reqReadyO), 64'd0);
    chk($sformatf("R2 v%0d hold not yet", idx), 64'(addrHoldO), 64'd0);
    @(negedge clk);                                   // E1
    chk($sformatf("R2 v%0d hold rises", idx), 64'(addrHoldO), 64'd1);
    chk($sformatf("R2 v%0d slot freed", idx), 64'(reqReadyO), 64'd1);
    @(negedge clk);                                   // E2
    chk($sformatf("R3 v%0d no early strobe", idx), 64'(snoopStrbO), 64'd0);
    @(negedge clk);                                   // E3
    chk($sformatf("R3 v%0d strobe", idx), 64'(snoopStrbO), 64'd1);
    chk($sformatf("R4 v%0d inv", idx), 64'(snoopInvO), 64'(v.inv));
    chk($sformatf("R4 v%0d addr", idx), 64'(snoopAddrO), 64'(v.addr));
    @(negedge clk);                                   // E4
    chk($sformatf("R3 v%0d strobe one clock", idx), 64'(snoopStrbO), 64'd0);
    chk($sformatf("R4 v%0d inv low", idx), 64'(snoopInvO), 64'd0);
    @(negedge clk);                                   // E5
    modHitI = v.hit;
    cpuReadyI = v.finAtSample; cpuLastI = v.finAtSample;
    #1;
    chk($sformatf("R9 v%0d ready passes", idx), 64'(readyAcceptO), 64'(v.finAtSample));
    chk($sformatf("R5 v%0d hold until sample", idx), 64'(addrHoldO), 64'd1);
    @(negedge clk);                                   // E6 sample edge
    cpuReadyI = 1'b0; cpuLastI = 1'b0;
    chk($sformatf("R6/R7/R8 v%0d backoff", idx), 64'(backoffO), 64'(v.expBoff));
    chk($sformatf("R5/R6/R7 v%0d hold", idx), 64'(addrHoldO), 64'(v.expBoff));
    if (v.expBoff) begin
      cpuReadyI = 1'b1;
      #1;
      chk($sformatf("R9 v%0d ready masked", idx), 64'(readyAcceptO), 64'd0);
    end
    @(negedge clk);                                   // E7
    cpuReadyI = 1'b0;
    chk($sformatf("R6 v%0d backoff one clock", idx), 64'(backoffO), 64'd0);
    chk($sformatf("R6 v%0d hold released", idx), 64'(addrHoldO), 64'd0);
    if (v.hit) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk($sformatf("R10 v%0d no restart", idx), 64'(addrHoldO | snoopStrbO), 64'd0);
      end
      modHitI = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hold in reset", 64'(addrHoldO), 64'd0);
    chk("R1 outputs in reset", 64'({snoopStrbO, snoopInvO, backoffO, readyAcceptO}), 64'd0);
    chk("R1 ready in reset", 64'(reqReadyO), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 addr after reset", 64'(snoopAddrO), 64'd0);
    chk("R1 hold after reset", 64'(addrHoldO), 64'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // queued request waits for the modified-hit line to drop
    reqValidI = 1'b1; reqAddrI = 32'h0000_A000; reqInvI = 1'b1;
    @(negedge clk);                                   // E0
    reqValidI = 1'b0;
    @(negedge clk);                                   // E1
    reqValidI = 1'b1; reqAddrI = 32'h0000_B000; reqInvI = 1'b0;
    @(negedge clk);                                   // E2: B captured
    reqValidI = 1'b0;
    chk("R2 slot occupied", 64'(reqReadyO), 64'd0);
    reqValidI = 1'b1; reqAddrI = 32'h0000_C000; reqInvI = 1'b1;   // dropped
    @(negedge clk);                                   // E3
    reqValidI = 1'b0;
    chk("R4 first addr", 64'(snoopAddrO), 64'h0000_A000);
    @(negedge clk);                                   // E4
    @(negedge clk);                                   // E5
    modHitI = 1'b1;
    @(negedge clk);                                   // E6
    chk("R7 no backoff without burst", 64'(backoffO), 64'd0);
    chk("R7 hold drops", 64'(addrHoldO), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 pending waits on hit", 64'(addrHoldO), 64'd0);
    end
    modHitI = 1'b0;
    @(negedge clk);
    chk("R10 idle edge", 64'(addrHoldO), 64'd0);
    @(negedge clk);
    chk("R10 pending starts", 64'(addrHoldO), 64'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R3 queued strobe", 64'(snoopStrbO), 64'd1);
    chk("R2 queued addr kept, overflow dropped", 64'(snoopAddrO), 64'h0000_B000);
    chk("R4 queued inv", 64'(snoopInvO), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 hold before sample", 64'(addrHoldO), 64'd1);
    @(negedge clk);
    chk("R5 miss releases hold", 64'(addrHoldO), 64'd0);
    chk("R2 slot empty at end", 64'(reqReadyO), 64'd1);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule